// File: doc/BRIEF.md
# UART Modem Control and Status Block

This block serves one channel of a 16550-style UART. It owns the interrupt-enable and modem-control registers and the modem-status register. A host reaches them over a small 8-bit register bus with an address, write and read strobes. The control register drives three active-low handshake outputs (terminal ready, request to send, user output 2). The same control bit that drives output 2 also decides whether the channel interrupt pin is driven or left floating. The four active-low modem inputs (clear to send, data set ready, ring, carrier) pass through synchronizers. They are shown as active-high status bits. Each input also has a sticky change flag, and any set flag can raise a modem-status interrupt.

The modem lines only report state. They never gate transmit or receive. A loopback mode ties the serial transmit stream from the shifter straight to the receiver input and holds the transmit pin at idle. In that mode the four control bits stand in for the external modem inputs, and the handshake outputs are forced inactive. Shift registers, FIFOs and baud timing live elsewhere.

Top module: `uart_modem_ctl`

## Requirements
- R1: A register write to address 4 with bit 0 set drives `dtr_n` low from the next cycle, unless loopback (bit 4) is set. Writing bit 0 clear, or reset, drives it high.
- R2: Bit 1 of the control register (address 4) drives `rts_n` low in the same way. It is high after reset and during loopback.
- R3: With control bit 3 set, `irq_oe` is 1 and `op2_n` is 0. `op2_n` is forced to 1 in loopback. With bit 3 clear, `irq_oe` is 0, `op2_n` is 1 and `irq_o` is 0.
- R4: `irq_o` is 1 exactly when control bit 3 is set, interrupt-enable bit 3 (address 1) is set, and at least one of status bits 3:0 is set.
- R5: Status register (address 6) bits 4, 5, 6 and 7 read as the inverted, synchronized `cts_n`, `dsr_n`, `ri_n` and `cd_n`. A pin change shows three clock edges after it is sampled: two synchronizer flops plus the status flop.
- R6: Status bits 0, 1 and 3 latch any change of clear-to-send, data-set-ready and carrier. Bit 2 latches only when `ri_n` goes from low to high.
- R7: A read of address 6 returns the current value and clears bits 3:0 at the following edge. A change detected at that same edge still sets its bit.
- R8: With control bit 4 set, `rx_ser_o` follows `tx_ser_i` and ignores `rx_pin`. `tx_pin` is 1 from the next edge. `dtr_n`, `rts_n` and `op2_n` are 1. The status inputs become clear-to-send = control bit 1, data-set-ready = bit 0, ring = bit 2, carrier = bit 3.
- R9: Synchronous active-high reset clears the interrupt-enable, control and status registers, drives `dtr_n`, `rts_n`, `op2_n` and `tx_pin` to 1, and drives `irq_oe` and `irq_o` to 0.
- R10: Address 1 reads back the low 4 interrupt-enable bits and address 4 the low 5 control bits, with upper bits 0. Other addresses, or `rd_en` low, read 0. The modem inputs never change `tx_pin` or `rx_ser_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational while `rd_en` is high |
| cts_n | input | 1 | Clear to send, active low |
| dsr_n | input | 1 | Data set ready, active low |
| ri_n | input | 1 | Ring indicator, active low |
| cd_n | input | 1 | Carrier detect, active low |
| dtr_n | output | 1 | Terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| op2_n | output | 1 | User output 2, active low |
| irq_o | output | 1 | Channel interrupt level |
| irq_oe | output | 1 | Drive enable for the interrupt pin (0 = high impedance) |
| tx_ser_i | input | 1 | Serial data from the transmit shifter |
| tx_pin | output | 1 | Serial transmit pin |
| rx_pin | input | 1 | Serial receive pin |
| rx_ser_o | output | 1 | Serial data to the receive shifter |

## Verification
The delicate overlap is a status read that clears the change flags at the same edge where a freshly synchronized input change tries to set one. The bench releases a pin change and times the read of address 6 so that the read's clearing edge is the third edge after the change was sampled. It expects the first read to show the old flags and a follow-up read to show the new flag still set. The behavioural reference model also meets this overlap many times during the random phase, where reads, control writes, loopback toggles and pin flips all mix at random.

// File: rtl/uart_modem_pkg.sv
package uart_modem_pkg;

    localparam logic [2:0] ADDR_IER = 3'd1;
    localparam logic [2:0] ADDR_MCR = 3'd4;
    localparam logic [2:0] ADDR_MSR = 3'd6;
    localparam int         IER_W         = 4;
    localparam int         IER_MODEM_BIT = 3;

    // Active-high view of the four modem inputs; bit order matches status bits 7:4.
    typedef struct packed {
        logic cd;
        logic ri;
        logic dsr;
        logic cts;
    } modem_lines_t;

    // Control register, bit 0 at the bottom.
    typedef struct packed {
        logic loop;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } mcr_t;

    function automatic modem_lines_t loop_map(input mcr_t m);
        modem_lines_t r;
        r.cts = m.rts;
        r.dsr = m.dtr;
        r.ri  = m.out1;
        r.cd  = m.out2;
        return r;
    endfunction

    // Change flags: any toggle, except ring which flags only on the trailing edge.
    function automatic modem_lines_t delta_of(input modem_lines_t prev, input modem_lines_t cur);
        modem_lines_t d;
        d.cts = prev.cts ^ cur.cts;
        d.dsr = prev.dsr ^ cur.dsr;
        d.cd  = prev.cd  ^ cur.cd;
        d.ri  = prev.ri  & ~cur.ri;
        return d;
    endfunction

endpackage

// File: rtl/uart_modem_sync.sv
module uart_modem_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Inputs are active low, so the flops idle at all ones.
    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '1;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/uart_modem_status.sv
module uart_modem_status
    import uart_modem_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  modem_lines_t lines_i,
    input  logic         clr_i,
    output modem_lines_t stat_o,
    output modem_lines_t delta_o
);
    modem_lines_t stat_q, delta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q  <= '0;
            delta_q <= '0;
        end else begin
            stat_q  <= lines_i;
            delta_q <= (clr_i ? modem_lines_t'('0) : delta_q) | delta_of(stat_q, lines_i);
        end
    end

    assign stat_o  = stat_q;
    assign delta_o = delta_q;

    AST_RI_TRAIL_FLAG: assert property (@(posedge clk) disable iff (rst)
        (stat_q.ri && !lines_i.ri) |=> delta_q.ri); // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (clr_i && lines_i == stat_q) |=> (delta_q == '0)); // R7
    AST_STATUS_TRACKS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (stat_q == $past(lines_i))); // R5
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
    import uart_modem_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              ri_n,
    input  logic              cd_n,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              op2_n,
    output logic              irq_o,
    output logic              irq_oe,
    input  logic              tx_ser_i,
    output logic              tx_pin,
    input  logic              rx_pin,
    output logic              rx_ser_o
);
    localparam int MCR_W   = $bits(mcr_t);
    localparam int LINES_W = $bits(modem_lines_t);

    logic [IER_W-1:0] ier_q;
    mcr_t             mcr_q;
    logic             tx_q;
    logic [LINES_W-1:0] pins_sync_n;
    modem_lines_t     ext_lines, lines_now, stat, delta;
    logic             sel_ier, sel_mcr, sel_msr;
    logic             unused_wdata;

    assign sel_ier = (addr == ADDR_W'(ADDR_IER));
    assign sel_mcr = (addr == ADDR_W'(ADDR_MCR));
    assign sel_msr = (addr == ADDR_W'(ADDR_MSR));
    assign unused_wdata = ^wdata[DATA_W-1:MCR_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ier_q <= '0;
            mcr_q <= '0;
            tx_q  <= 1'b1;
        end else begin
            if (wr_en && sel_ier) ier_q <= wdata[IER_W-1:0];
            if (wr_en && sel_mcr) mcr_q <= mcr_t'(wdata[MCR_W-1:0]);
            tx_q <= mcr_q.loop ? 1'b1 : tx_ser_i;
        end
    end

    uart_modem_sync #(.WIDTH(LINES_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  ({cd_n, ri_n, dsr_n, cts_n}),
        .dout (pins_sync_n)
    );

    assign ext_lines = modem_lines_t'(~pins_sync_n);
    assign lines_now = mcr_q.loop ? loop_map(mcr_q) : ext_lines;

    uart_modem_status status_i (
        .clk     (clk),
        .rst     (rst),
        .lines_i (lines_now),
        .clr_i   (rd_en && sel_msr),
        .stat_o  (stat),
        .delta_o (delta)
    );

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (sel_ier)      rdata = DATA_W'(ier_q);
            else if (sel_mcr) rdata = DATA_W'(mcr_q);
            else if (sel_msr) rdata = DATA_W'({stat, delta});
        end
    end

    assign dtr_n    = ~(mcr_q.dtr  & ~mcr_q.loop);
    assign rts_n    = ~(mcr_q.rts  & ~mcr_q.loop);
    assign op2_n    = ~(mcr_q.out2 & ~mcr_q.loop);
    assign irq_oe   = mcr_q.out2;
    assign irq_o    = mcr_q.out2 & ier_q[IER_MODEM_BIT] & (|delta);
    assign tx_pin   = tx_q;
    assign rx_ser_o = mcr_q.loop ? tx_ser_i : rx_pin;

    AST_DTR_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel_mcr && !wdata[4]) |=> (dtr_n == !$past(wdata[0]))); // R1
    AST_RTS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel_mcr && !wdata[4]) |=> (rts_n == !$past(wdata[1]))); // R2
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        !irq_oe |-> !irq_o); // R3
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ier_q[IER_MODEM_BIT]); // R4
    AST_LOOP_TX_IDLE: assert property (@(posedge clk) disable iff (rst)
        mcr_q.loop |=> tx_pin); // R8
endmodule

// File: tb/uart_modem_ctl_tb.sv
`timescale 1ns/1ps
module uart_modem_ctl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, cd_n = 1'b1;
    logic       dtr_n, rts_n, op2_n, irq_o, irq_oe;
    logic       tx_ser_i = 1'b1, rx_pin = 1'b1;
    logic       tx_pin, rx_ser_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit sb_on = 0;

    always #2.5 clk = ~clk;

    uart_modem_ctl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cts_n(cts_n), .dsr_n(dsr_n),
        .ri_n(ri_n), .cd_n(cd_n), .dtr_n(dtr_n), .rts_n(rts_n),
        .op2_n(op2_n), .irq_o(irq_o), .irq_oe(irq_oe), .tx_ser_i(tx_ser_i),
        .tx_pin(tx_pin), .rx_pin(rx_pin), .rx_ser_o(rx_ser_o)
    );

    // Behavioural reference model, pins kept as {cd, ri, dsr, cts}.
    logic [3:0] m_ier, m_stat, m_delta, m_p1, m_p2;
    logic [4:0] m_mcr;
    logic       m_tx;

    always @(posedge clk) begin
        logic [3:0] nxt, chg;
        if (rst) begin
            m_ier = 0; m_mcr = 0; m_stat = 0; m_delta = 0;
            m_p1 = 4'hF; m_p2 = 4'hF; m_tx = 1; sb_on = 1;
        end else begin
            nxt = m_mcr[4] ? {m_mcr[3], m_mcr[2], m_mcr[0], m_mcr[1]} : ~m_p2;
            chg[0] = nxt[0] != m_stat[0];
            chg[1] = nxt[1] != m_stat[1];
            chg[3] = nxt[3] != m_stat[3];
            chg[2] = m_stat[2] && !nxt[2];
            if (rd_en && addr == 6) m_delta = 0;
            m_delta = m_delta | chg;
            m_stat = nxt;
            m_tx = m_mcr[4] ? 1'b1 : tx_ser_i;
            if (wr_en && addr == 1) m_ier = wdata[3:0];
            if (wr_en && addr == 4) m_mcr = wdata[4:0];
            m_p2 = m_p1;
            m_p1 = {cd_n, ri_n, dsr_n, cts_n};
        end
    end

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output on every falling edge, before new stimulus.
    always @(negedge clk) begin
        logic [7:0] exp_rd;
        if (sb_on && !done) begin
            exp_rd = 0;
            if (rd_en) begin
                if (addr == 1) exp_rd = {4'b0, m_ier};
                else if (addr == 4) exp_rd = {3'b0, m_mcr};
                else if (addr == 6) exp_rd = {m_stat, m_delta};
            end
            check8("R1 dtr_n", {7'b0, dtr_n}, {7'b0, ~(m_mcr[0] & ~m_mcr[4])});
            check8("R2 rts_n", {7'b0, rts_n}, {7'b0, ~(m_mcr[1] & ~m_mcr[4])});
            check8("R3 op2_n", {7'b0, op2_n}, {7'b0, ~(m_mcr[3] & ~m_mcr[4])});
            check8("R3 irq_oe", {7'b0, irq_oe}, {7'b0, m_mcr[3]});
            check8("R4 irq_o", {7'b0, irq_o}, {7'b0, m_mcr[3] & m_ier[3] & (|m_delta)});
            check8("R8 tx_pin", {7'b0, tx_pin}, {7'b0, m_tx});
            check8("R8 rx_ser_o", {7'b0, rx_ser_o}, {7'b0, m_mcr[4] ? tx_ser_i : rx_pin});
            check8("R10 rdata", rdata, exp_rd);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk); #1;
        wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); #1;
        rd_en = 1; addr = a;
        #1 d = rdata;
        @(negedge clk); #1;
        rd_en = 0;
    endtask

    initial begin
        logic [7:0] v;
        cyc(3);
        rst = 0;
        // Reset state
        check8("R9 dtr_n after reset", {7'b0, dtr_n}, 8'd1);
        check8("R9 rts_n after reset", {7'b0, rts_n}, 8'd1);
        check8("R9 op2_n after reset", {7'b0, op2_n}, 8'd1);
        check8("R9 irq_oe after reset", {7'b0, irq_oe}, 8'd0);
        check8("R9 tx_pin after reset", {7'b0, tx_pin}, 8'd1);
        rd(3'd4, v); check8("R9 control reg after reset", v, 8'h00);
        rd(3'd6, v); check8("R9 status reg after reset", v, 8'h00);

        // Handshake outputs
        wr(3'd4, 8'h01); check8("R1 dtr_n low", {7'b0, dtr_n}, 8'd0);
        wr(3'd4, 8'h03); check8("R2 rts_n low", {7'b0, rts_n}, 8'd0);
        wr(3'd4, 8'h08);
        check8("R1 dtr_n back high", {7'b0, dtr_n}, 8'd1);
        check8("R3 irq_oe driven", {7'b0, irq_oe}, 8'd1);
        check8("R3 op2_n low", {7'b0, op2_n}, 8'd0);

        // Modem status and interrupt
        wr(3'd1, 8'h08);
        cts_n = 0; cyc(4);
        check8("R4 irq_o on cts change", {7'b0, irq_o}, 8'd1);
        rd(3'd6, v); check8("R5 R6 status cts", v, 8'h11);
        rd(3'd6, v); check8("R7 flags cleared", v, 8'h10);
        check8("R4 irq_o dropped", {7'b0, irq_o}, 8'd0);
        ri_n = 0; cyc(4);
        rd(3'd6, v); check8("R6 ring leading edge no flag", v, 8'h50);
        ri_n = 1; cyc(4);
        rd(3'd6, v); check8("R6 ring trailing edge flag", v, 8'h14);

        // Read colliding with a new change
        @(negedge clk); #1 cts_n = 1;
        @(negedge clk); @(negedge clk); #1;
        rd_en = 1; addr = 3'd6;
        #1 v = rdata;
        check8("R7 read before collision", v, 8'h10);
        @(negedge clk); #1 rd_en = 0;
        rd(3'd6, v); check8("R7 change survives clear", v, 8'h01);

        // Loopback
        wr(3'd4, 8'h1B);
        check8("R8 dtr_n forced", {7'b0, dtr_n}, 8'd1);
        check8("R8 rts_n forced", {7'b0, rts_n}, 8'd1);
        check8("R8 op2_n forced", {7'b0, op2_n}, 8'd1);
        tx_ser_i = 0; rx_pin = 1; cts_n = 0; cd_n = 0;
        #1 check8("R8 rx follows tx", {7'b0, rx_ser_o}, 8'd0);
        cyc(2);
        check8("R8 tx_pin idle", {7'b0, tx_pin}, 8'd1);
        rd(3'd6, v); check8("R8 status from control bits", v, 8'hBB);
        rd(3'd1, v); check8("R10 enable readback", v, 8'h08);
        rd(3'd0, v); check8("R10 unmapped address", v, 8'h00);
        wr(3'd4, 8'h00);
        cts_n = 1; cd_n = 1; tx_ser_i = 1;
        cyc(4);
        rd(3'd6, v);

        // Random phase against the model
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk); #1;
            rst   = ($urandom % 300) == 0;
            wr_en = ($urandom % 4) == 0;
            rd_en = ($urandom % 3) == 0;
            case ($urandom % 5)
                0: addr = 3'd1;
                1: addr = 3'd4;
                2: addr = 3'd6;
                3: addr = 3'd6;
                default: addr = 3'd3;
            endcase
            wdata = 8'($urandom);
            if ($urandom % 8 == 0) cts_n = ~cts_n;
            if ($urandom % 8 == 0) dsr_n = ~dsr_n;
            if ($urandom % 8 == 0) ri_n  = ~ri_n;
            if ($urandom % 8 == 0) cd_n  = ~cd_n;
            tx_ser_i = 1'($urandom);
            rx_pin   = 1'($urandom);
        end
        @(negedge clk); #1;
        rst = 0; wr_en = 0; rd_en = 0;
        cyc(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule